// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the byte-wide register side of an asynchronous serial port. It sits between a simple read/write bus and two byte streams. The incoming stream delivers received characters and the outgoing stream carries characters to be sent. The bit engine, baud tick and framing live elsewhere. The block keeps the status, control, format and baud divisor registers. It holds at most one received character, trims that character to the configured character size, and drives three level interrupt lines for receive done, transmit done and transmit register empty.

Software writes the control register to enable the receiver and the transmitter and to pick the interrupts it wants. It then moves characters through the shared data offset. A power-down input holds every register at its reset value, makes reads return zero, and drops writes.

Top module: `usart_ctrl_front`

## Requirements
- R1: After reset the registers read as follows: status 0x20, control 0x00, format 0x06, baud low 0x00, baud high 0x00. All three interrupt lines are low.
- R2: The offsets are 0 status, 1 control, 2 format, 3 baud low, 4 baud high and 5 data. Offsets 6 and 7 read 0, and writes to them change no register.
- R3: Status bit positions are receive-done 7, transmit-done 6 and empty 5. A status write stores bits 1:0 and leaves bits 7, 5, 4, 3 and 2 unchanged. Any status write leaves transmit-done clear, so the transmit interrupt drops.
- R4: Control bits are receive-interrupt enable 7, transmit-interrupt enable 6, empty-interrupt enable 5, receive enable 4, transmit enable 3 and size bit 2 at bit 2. A control write stores every bit except bit 1, which always reads 0.
- R5: Baud low and format store the full byte. Baud high stores only its low 4 bits, and its upper bits read 0.
- R6: The size code is {control[2], format[2], format[1]}. Codes 0 to 3 keep the low 5, 6, 7 or 8 bits of a received character. Code 7 keeps 8 bits. Codes 4 to 6 keep the mask that was in force before. The code is re-evaluated on every control write and every format write.
- R7: rx_ready is high only while receive is enabled and no character is held. A handshake stores the byte and sets receive-done.
- R8: A data read with receive enabled returns the held byte ANDed with the size mask, or 0 if nothing is held. It empties the holder and clears receive-done. With receive disabled, a data read returns 0 and changes nothing.
- R9: A control write with receive enable at 0 discards a held character. Receive-done is left as it was.
- R10: A data write with transmit disabled is ignored. Otherwise tx_valid rises in the write cycle with the written byte. Acceptance sets transmit-done and empty. If the byte is not taken in that cycle, tx_data holds steady and empty stays clear until the byte is accepted. Data writes while a byte is pending are ignored.
- R11: Each interrupt line equals its enable bit ANDed with its flag, at all times.
- R12: While pwr_off is high the block holds its reset state, rdata is 0, writes are dropped, and rx_ready and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_off | input | 1 | Power-down hold |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (data offset read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holder can take a byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq_rxc | output | 1 | Receive-done interrupt |
| irq_txc | output | 1 | Transmit-done interrupt |
| irq_dre | output | 1 | Transmit-empty interrupt |

## Verification
The properties assume that a bus access is either a read or a write, never both in one cycle. They also assume that a control write which turns the receiver off never lands in the same cycle as a receive handshake. The stimulus keeps to both rules: its tasks drive exactly one strobe and return it low before the next access, and every receive push happens between register accesses. All inputs change on the falling clock edge. The bench also keeps the transmitter's ready steady across each data write, which the tx_data stability property relies on.

// File: rtl/usart_front_pkg.sv
package usart_front_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 3;

    localparam logic [ADDR_W-1:0] REG_STAT    = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL    = 3'd1;
    localparam logic [ADDR_W-1:0] REG_FMT     = 3'd2;
    localparam logic [ADDR_W-1:0] REG_BAUD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] REG_BAUD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] REG_DATA    = 3'd5;

    localparam int CB_RXIE = 7;
    localparam int CB_TXIE = 6;
    localparam int CB_DRIE = 5;
    localparam int CB_RXEN = 4;
    localparam int CB_TXEN = 3;
    localparam int CB_SZ2  = 2;
    localparam int FB_SZ1  = 2;
    localparam int FB_SZ0  = 1;

    localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hFD;
    localparam logic [BYTE_W-1:0] FMT_RESET  = 8'h06;
    localparam logic [BYTE_W-1:0] FULL_MASK  = 8'hFF;

    typedef struct packed {
        logic       rxc;
        logic       txc;
        logic       dre;
        logic [2:0] zero;
        logic [1:0] opt;
    } stat_t;

    function automatic logic [BYTE_W-1:0] size_mask(input logic [CODE_W-1:0] code,
                                                    input logic [BYTE_W-1:0] cur);
        case (code)
            3'd0:       return 8'h1F;
            3'd1:       return 8'h3F;
            3'd2:       return 8'h7F;
            3'd3, 3'd7: return FULL_MASK;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/usart_size_decode.sv
module usart_size_decode
    import usart_front_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              upd,
    input  logic [CODE_W-1:0] code,
    output logic [BYTE_W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (clr)      mask <= FULL_MASK;
        else if (upd) mask <= size_mask(code, mask);
    end

    // R6: reserved codes leave the mask alone
    p_reserved_keeps_r6: assert property (@(posedge clk) disable iff (clr)
        (upd && (code inside {3'd4, 3'd5, 3'd6})) |=> $stable(mask));

endmodule

// File: rtl/usart_rx_hold.sv
module usart_rx_hold
    import usart_front_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic              flush,
    input  logic              take,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              held,
    output logic [BYTE_W-1:0] held_byte,
    output logic              accept
);

    assign rx_ready = en && !held;
    assign accept   = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (clr) begin
            held      <= 1'b0;
            held_byte <= '0;
        end else if (flush) begin
            held <= 1'b0;
        end else if (accept) begin
            held      <= 1'b1;
            held_byte <= rx_data;
        end else if (take) begin
            held <= 1'b0;
        end
    end

    // R7: a handshake leaves a byte in the holder
    p_accept_holds_r7: assert property (@(posedge clk) disable iff (clr)
        (accept && !flush) |=> held);

    // R8: a data read empties the holder
    p_take_empties_r8: assert property (@(posedge clk) disable iff (clr)
        (take && !accept && !flush) |=> !held);

endmodule

// File: rtl/usart_tx_stage.sv
module usart_tx_stage
    import usart_front_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_fire,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              busy,
    output logic              done
);

    logic              pend;
    logic [BYTE_W-1:0] pend_byte;

    assign busy     = pend;
    assign tx_valid = pend || wr_fire;
    assign tx_data  = pend ? pend_byte : wr_byte;
    assign done     = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (clr) begin
            pend      <= 1'b0;
            pend_byte <= '0;
        end else if (done) begin
            pend <= 1'b0;
        end else if (wr_fire) begin
            pend      <= 1'b1;
            pend_byte <= wr_byte;
        end
    end

    // R10: a stalled byte stays offered and unchanged
    p_tx_stall_stable_r10: assert property (@(posedge clk) disable iff (clr)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/usart_ctrl_front.sv
module usart_ctrl_front
    import usart_front_pkg::*;
#(
    parameter int BAUD_HI_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_off,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq_rxc,
    output logic              irq_txc,
    output logic              irq_dre
);

    localparam logic [BYTE_W-1:0] BAUD_HI_MASK = BYTE_W'((1 << BAUD_HI_BITS) - 1);

    logic clr;
    logic wr_ok, rd_ok;
    logic wr_stat, wr_ctrl, wr_fmt, wr_blo, wr_bhi, wr_data, rd_data;

    logic                    rxc_f, txc_f, dre_f;
    logic [1:0]              stat_opt;
    logic [BYTE_W-1:0]       ctrl_q, ctrl_new, fmt_q, baud_lo_q;
    logic [BAUD_HI_BITS-1:0] baud_hi_q;
    stat_t                   stat_view;

    logic              size_upd;
    logic [CODE_W-1:0] size_code;
    logic [BYTE_W-1:0] char_mask;

    logic              rx_en, rx_flush, rx_take, rx_held, rx_accept;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_fire, tx_busy, tx_done;

    assign clr   = rst || pwr_off;
    assign wr_ok = wr_en && !pwr_off;
    assign rd_ok = rd_en && !pwr_off;

    assign wr_stat = wr_ok && (addr == REG_STAT);
    assign wr_ctrl = wr_ok && (addr == REG_CTRL);
    assign wr_fmt  = wr_ok && (addr == REG_FMT);
    assign wr_blo  = wr_ok && (addr == REG_BAUD_LO);
    assign wr_bhi  = wr_ok && (addr == REG_BAUD_HI);
    assign wr_data = wr_ok && (addr == REG_DATA);
    assign rd_data = rd_ok && (addr == REG_DATA);

    assign ctrl_new = (wdata & CTRL_WMASK) | (ctrl_q & ~CTRL_WMASK);

    // size code from whichever register is being written this cycle
    assign size_upd  = wr_ctrl || wr_fmt;
    assign size_code = wr_ctrl ? {ctrl_new[CB_SZ2], fmt_q[FB_SZ1], fmt_q[FB_SZ0]}
                               : {ctrl_q[CB_SZ2], wdata[FB_SZ1], wdata[FB_SZ0]};

    usart_size_decode u_size (
        .clk  (clk),
        .clr  (clr),
        .upd  (size_upd),
        .code (size_code),
        .mask (char_mask)
    );

    assign rx_en    = ctrl_q[CB_RXEN] && !pwr_off;
    assign rx_flush = wr_ctrl && !wdata[CB_RXEN];
    assign rx_take  = rd_data && ctrl_q[CB_RXEN];

    usart_rx_hold u_rx (
        .clk       (clk),
        .clr       (clr),
        .en        (rx_en),
        .flush     (rx_flush),
        .take      (rx_take),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .held      (rx_held),
        .held_byte (rx_byte),
        .accept    (rx_accept)
    );

    assign tx_fire = wr_data && ctrl_q[CB_TXEN] && !tx_busy;

    usart_tx_stage u_tx (
        .clk      (clk),
        .clr      (clr),
        .wr_fire  (tx_fire),
        .wr_byte  (wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .busy     (tx_busy),
        .done     (tx_done)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            rxc_f     <= 1'b0;
            txc_f     <= 1'b0;
            dre_f     <= 1'b1;
            stat_opt  <= 2'b00;
            ctrl_q    <= '0;
            fmt_q     <= FMT_RESET;
            baud_lo_q <= '0;
            baud_hi_q <= '0;
        end else begin
            if (rx_accept)    rxc_f <= 1'b1;
            else if (rx_take) rxc_f <= 1'b0;

            if (tx_done)      txc_f <= 1'b1;
            else if (wr_stat) txc_f <= 1'b0;

            if (tx_done)      dre_f <= 1'b1;
            else if (tx_fire) dre_f <= 1'b0;

            if (wr_stat) stat_opt  <= wdata[1:0];
            if (wr_ctrl) ctrl_q    <= ctrl_new;
            if (wr_fmt)  fmt_q     <= wdata;
            if (wr_blo)  baud_lo_q <= wdata;
            if (wr_bhi)  baud_hi_q <= wdata[BAUD_HI_BITS-1:0];
        end
    end

    assign stat_view = '{rxc: rxc_f, txc: txc_f, dre: dre_f, zero: 3'b000, opt: stat_opt};

    assign irq_rxc = ctrl_q[CB_RXIE] && rxc_f;
    assign irq_txc = ctrl_q[CB_TXIE] && txc_f;
    assign irq_dre = ctrl_q[CB_DRIE] && dre_f;

    always_comb begin
        rdata = '0;
        if (!pwr_off) begin
            case (addr)
                REG_STAT:    rdata = stat_view;
                REG_CTRL:    rdata = ctrl_q;
                REG_FMT:     rdata = fmt_q;
                REG_BAUD_LO: rdata = baud_lo_q;
                REG_BAUD_HI: rdata = BYTE_W'(baud_hi_q);
                REG_DATA:    rdata = (ctrl_q[CB_RXEN] && rx_held) ? (rx_byte & char_mask) : '0;
                default:     rdata = '0;
            endcase
        end
    end

    // R12: one cycle of power-down leaves everything quiet
    p_pwr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        pwr_off |=> (!irq_rxc && !irq_txc && !irq_dre && !rx_ready && !tx_valid));

    // R5: upper bits of the high baud byte never show
    p_bhi_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_BAUD_HI) |-> ((rdata & ~BAUD_HI_MASK) == '0));

    // R10: empty flag low only while a byte waits at the transmitter
    p_dre_low_pending_r10: assert property (@(posedge clk) disable iff (clr)
        !dre_f |-> tx_valid);

    // R3: a status write drops the transmit-done interrupt
    p_stat_wr_drops_txc_r3: assert property (@(posedge clk) disable iff (clr)
        (wr_stat && !tx_done) |=> !irq_txc);

    // R11: receive interrupt follows an accepted byte when enabled
    p_rx_irq_on_accept_r11: assert property (@(posedge clk) disable iff (clr)
        (rx_accept && ctrl_q[CB_RXIE] && !wr_ctrl) |=> irq_rxc);

endmodule

// File: tb/tb_usart_ctrl_front.sv
module tb_usart_ctrl_front;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_off = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       irq_rxc, irq_txc, irq_dre;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    usart_ctrl_front dut (
        .clk(clk), .rst(rst), .pwr_off(pwr_off),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
    );

    // {req[3:0], is_write, addr[2:0], data[7:0]}
    localparam int NV = 30;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1, 1'b0, 3'd0, 8'h20}, {4'd1, 1'b0, 3'd1, 8'h00}, {4'd1, 1'b0, 3'd2, 8'h06},
        {4'd1, 1'b0, 3'd3, 8'h00}, {4'd1, 1'b0, 3'd4, 8'h00},
        {4'd2, 1'b0, 3'd6, 8'h00}, {4'd2, 1'b0, 3'd7, 8'h00},
        {4'd5, 1'b1, 3'd3, 8'hA5}, {4'd5, 1'b0, 3'd3, 8'hA5}, {4'd5, 1'b1, 3'd4, 8'hFF},
        {4'd5, 1'b0, 3'd4, 8'h0F}, {4'd5, 1'b1, 3'd2, 8'h86}, {4'd5, 1'b0, 3'd2, 8'h86},
        {4'd5, 1'b1, 3'd2, 8'h06},
        {4'd4, 1'b1, 3'd1, 8'hFF}, {4'd4, 1'b0, 3'd1, 8'hFD}, {4'd4, 1'b1, 3'd1, 8'h02},
        {4'd4, 1'b0, 3'd1, 8'h00},
        {4'd3, 1'b1, 3'd0, 8'hFF}, {4'd3, 1'b0, 3'd0, 8'h23}, {4'd3, 1'b1, 3'd0, 8'h00},
        {4'd3, 1'b0, 3'd0, 8'h20},
        {4'd2, 1'b1, 3'd6, 8'h55}, {4'd2, 1'b1, 3'd7, 8'hAA}, {4'd2, 1'b0, 3'd0, 8'h20},
        {4'd2, 1'b0, 3'd1, 8'h00}, {4'd2, 1'b0, 3'd2, 8'h06}, {4'd2, 1'b0, 3'd3, 8'hA5},
        {4'd2, 1'b0, 3'd4, 8'h0F},
        {4'd8, 1'b0, 3'd5, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        check(req, {7'd0, act}, {7'd0, exp});
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_peek(input logic [2:0] a, input logic [7:0] d,
                           output logic tv, output logic [7:0] td);
        addr = a; wdata = d; wr_en = 1'b1;
        #1; tv = tx_valid; td = tx_data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] got;
        addr = a; rd_en = 1'b1;
        #1; got = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, got, exp);
    endtask

    task automatic push(input logic [7:0] d, output logic rdy);
        rx_valid = 1'b1; rx_data = d;
        #1; rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       rdy, tv;
        logic [7:0] td;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: interrupts low after reset
        check1("R1 irq_rxc", irq_rxc, 1'b0);
        check1("R1 irq_txc", irq_txc, 1'b0);
        check1("R1 irq_dre", irq_dre, 1'b0);

        // R1 R2 R3 R4 R5 R8 register table
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            if (v[11]) wr(v[10:8], v[7:0]);
            else rd_chk(v[10:8], v[7:0], $sformatf("R%0d table %0d", v[15:12], i));
        end

        // R7 R8 R11 receive path
        wr(3'd1, 8'h90);
        check1("R11 rx irq idle", irq_rxc, 1'b0);
        push(8'hE7, rdy);
        check1("R7 ready when empty", rdy, 1'b1);
        check1("R7 ready drops when held", rx_ready, 1'b0);
        check1("R11 rx irq set", irq_rxc, 1'b1);
        rd_chk(3'd0, 8'hA0, "R7 receive-done flag");
        push(8'h11, rdy);
        check1("R7 second byte refused", rdy, 1'b0);
        rd_chk(3'd5, 8'hE7, "R8 held byte");
        check1("R8 rx irq cleared", irq_rxc, 1'b0);
        rd_chk(3'd0, 8'h20, "R8 flag cleared");
        rd_chk(3'd5, 8'h00, "R8 empty read");

        // R6 size codes
        wr(3'd2, 8'h00); push(8'hFF, rdy); rd_chk(3'd5, 8'h1F, "R6 five bits");
        wr(3'd2, 8'h02); push(8'hFF, rdy); rd_chk(3'd5, 8'h3F, "R6 six bits");
        wr(3'd2, 8'h04); push(8'hFF, rdy); rd_chk(3'd5, 8'h7F, "R6 seven bits");
        wr(3'd1, 8'h94); push(8'hFF, rdy); rd_chk(3'd5, 8'h7F, "R6 reserved keeps");
        wr(3'd2, 8'h06); push(8'hFF, rdy); rd_chk(3'd5, 8'hFF, "R6 code seven");

        // R9 discard and R8 disabled read
        wr(3'd1, 8'h90);
        push(8'h5A, rdy);
        wr(3'd1, 8'h80);
        check1("R7 ready off when disabled", rx_ready, 1'b0);
        rd_chk(3'd5, 8'h00, "R8 disabled read");
        rd_chk(3'd0, 8'hA0, "R8 disabled read keeps flag");
        check1("R11 rx irq kept", irq_rxc, 1'b1);
        wr(3'd1, 8'h90);
        check1("R9 holder emptied", rx_ready, 1'b1);
        rd_chk(3'd5, 8'h00, "R9 discarded byte");
        check1("R9 irq after read", irq_rxc, 1'b0);

        // R10 R11 R3 transmit path
        wr(3'd1, 8'h00);
        wr_peek(3'd5, 8'h33, tv, td);
        check1("R10 disabled write", tv, 1'b0);
        wr(3'd1, 8'h68);
        check1("R11 empty irq", irq_dre, 1'b1);
        wr_peek(3'd5, 8'h3C, tv, td);
        check1("R10 valid in write cycle", tv, 1'b1);
        check("R10 data in write cycle", td, 8'h3C);
        rd_chk(3'd0, 8'h60, "R10 flags after send");
        check1("R11 tx irq", irq_txc, 1'b1);
        wr(3'd0, 8'h00);
        check1("R3 tx irq dropped", irq_txc, 1'b0);
        rd_chk(3'd0, 8'h20, "R3 transmit-done cleared");

        tx_ready = 1'b0;
        wr_peek(3'd5, 8'h81, tv, td);
        check1("R10 stalled valid", tx_valid, 1'b1);
        check("R10 stalled data", tx_data, 8'h81);
        rd_chk(3'd0, 8'h00, "R10 empty clear while pending");
        check1("R11 empty irq low", irq_dre, 1'b0);
        wr_peek(3'd5, 8'h99, tv, td);
        check("R10 write while pending ignored", td, 8'h81);
        tx_ready = 1'b1;
        #1;
        check1("R10 offered on ready", tx_valid, 1'b1);
        @(negedge clk);
        check1("R10 gone after accept", tx_valid, 1'b0);
        rd_chk(3'd0, 8'h60, "R10 flags after late accept");

        // R12 power-down
        wr(3'd1, 8'hF8);
        pwr_off = 1'b1;
        @(negedge clk);
        check1("R12 irq_rxc", irq_rxc, 1'b0);
        check1("R12 irq_txc", irq_txc, 1'b0);
        check1("R12 irq_dre", irq_dre, 1'b0);
        check1("R12 rx_ready", rx_ready, 1'b0);
        rd_chk(3'd0, 8'h00, "R12 read while off");
        wr(3'd3, 8'h77);
        pwr_off = 1'b0;
        rd_chk(3'd1, 8'h00, "R12 control reset");
        rd_chk(3'd0, 8'h20, "R12 status reset");
        rd_chk(3'd2, 8'h06, "R12 format reset");
        rd_chk(3'd3, 8'h00, "R12 write dropped");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule